// File: doc/BRIEF.md
# Television Sound Decoder Control Slave

This block is the serial control port of a television multi-channel sound decoder. It is a two-wire (I2C) slave that holds one control byte for the audio path and returns one status byte. The control byte sets the test enable, the input choice (sound IF or baseband), the clock-out enable, the external source select, mute, forced mono and the two-bit language choice. A read returns the stereo and bilingual detector flags, together with a flag that shows whether the control byte still holds its power-up value.

The SCL and SDA lines are oversampled by the system clock. Each line passes through a two-flop synchronizer and a three-sample agreement filter. The 7-bit device address is chosen from three values by a three-level select input. When the test bit is set, a second byte in the same write frame chooses a test-monitor point. The system clock must run at least 20 times faster than SCL, which is at most 100 kHz.

Top module: `tvsnd_ctl_slave`

## Requirements
- R1: The address select sets the 7-bit address. 2'b00 (low) gives 0x50, 2'b01 (open) gives 0x40, 2'b10 (high) gives 0x42, and 2'b11 is treated as open. A matching address is acknowledged by pulling SDA low through the 9th SCL clock.
- R2: A mismatched address is not acknowledged. The slave then leaves SDA released and ignores every byte until the next START or STOP, and its registers do not change.
- R3: A read (R/W = 1) returns one byte MSB first: bit 7 stereo flag, bit 6 bilingual flag, bit 5 initial-condition flag, bits 4:0 zero. The flags are sampled when the address byte completes, so later changes do not affect that byte.
- R4: A STOP that arrives before all 8 bits of a data byte leaves the control and monitor registers unchanged.
- R5: After reset the control byte is 0x01 (language main, all other fields off), the monitor select is 0, the initial-condition flag is 1 and SDA is released.
- R6: The first data byte of a write is acknowledged and becomes the control byte once its 8th bit is in. The layout is bit 7 test, bit 6 baseband, bit 5 clock-out, bit 4 external source, bit 3 mute, bit 2 forced mono, bits 1:0 language (00 both, 01 main, 10 sub).
- R7: The first accepted control write clears the initial-condition flag, and nothing sets it again until reset.
- R8: A control byte with language code 11 is acknowledged and updates every other field, but the language field keeps its previous value.
- R9: When the control byte just written has the test bit set, a second data byte is acknowledged. A code from 0x00 to 0x0A becomes the monitor select, and a larger code leaves the select unchanged. A control write with the test bit clear resets the monitor select to 0.
- R10: A second data byte while the test bit is clear, and any third data byte, are not acknowledged and change nothing.
- R11: A pulse on SCL or SDA shorter than three system clocks is filtered out and does not disturb a transfer.
- R12: The slave pulls SDA only in an acknowledge slot or while sending a read data bit. It changes SDA only after a filtered SCL fall, a START or a STOP, and it releases SDA at a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples the bus) |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| addr_sel | input | 2 | Address select: 00 low, 01 open, 10 high |
| stereo_det | input | 1 | Stereo detector flag |
| bilingual_det | input | 1 | Bilingual detector flag |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| ctl_test | output | 1 | Test enable |
| ctl_baseband | output | 1 | Input choice: 0 sound IF, 1 baseband |
| ctl_clkout_en | output | 1 | Clock-out enable |
| ctl_ext_src | output | 1 | External source select |
| ctl_mute | output | 1 | Mute |
| ctl_force_mono | output | 1 | Forced mono |
| ctl_lang | output | 2 | Language: 00 both, 01 main, 10 sub |
| mon_sel | output | 4 | Test-monitor point select |

## Verification
Write frames are run at each of the three address-select settings, with addresses that match and addresses that do not. These frames separate address decode from the data path, and an unacknowledged frame shows that nothing was stored. Frames with one, two and three data bytes, under both values of the test bit, separate the monitor path from the control path. Frames cut after five or seven bits show that a partial byte never commits. Reads taken before and after the first write, with the detector flags flipped partway through the byte, show that the initial-condition flag works and that the flags are sampled at the address. A frame with short pulses injected on both lines exercises the input filter.

// File: rtl/tvsnd_ctl_pkg.sv
package tvsnd_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK,
    ST_SKIP
  } eng_state_t;

  typedef struct packed {
    logic       test;
    logic       baseband;
    logic       clkout;
    logic       ext_src;
    logic       mute;
    logic       mono;
    logic [1:0] lang;
  } ctl_t;

  // Address select: 00 low, 01 open, 10 high, 11 treated as open
  function automatic logic [6:0] pick_addr(input logic [1:0] sel,
                                           input logic [6:0] a_low,
                                           input logic [6:0] a_open,
                                           input logic [6:0] a_high);
    logic [6:0] a;
    case (sel)
      2'b00:   a = a_low;
      2'b10:   a = a_high;
      default: a = a_open;
    endcase
    return a;
  endfunction

  // New control value; language code 11 keeps the old language
  function automatic ctl_t merge_ctl(input ctl_t old, input logic [7:0] wr);
    ctl_t n;
    n = ctl_t'(wr);
    if (wr[1:0] == 2'b11) n.lang = old.lang;
    return n;
  endfunction

  function automatic logic [7:0] status_byte(input logic st, input logic bi,
                                             input logic init);
    return {st, bi, init, 5'b00000};
  endfunction

endpackage

// File: rtl/tvsnd_line_filter.sv
module tvsnd_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   VOTE_LEN    = 3,
  parameter logic RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_LEN-1:0]    hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      hist_q <= {VOTE_LEN{RST_VAL}};
      dout   <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       dout <= 1'b1;
      else if (~|hist_q) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/tvsnd_bus_events.sv
module tvsnd_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign bus_start = scl & scl_d & sda_d & ~sda;
  assign bus_stop  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/tvsnd_byte_engine.sv
module tvsnd_byte_engine
  import tvsnd_ctl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_bit,
  input  logic [BYTE_W-2:0] my_addr,
  input  logic              test_on,
  input  logic [BYTE_W-1:0] stat_byte,
  output logic              sda_pull,
  output logic              ctl_wr,
  output logic              mon_wr,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              ack_slot,
  output logic              rd_slot
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full;
  logic [BYTE_W-1:0] sh_in;
  logic [BYTE_W-1:0] sh_out;
  logic [BYTE_W-1:0] rd_cap;
  logic              rd_mode;
  logic [1:0]        byte_idx;
  logic              byte_done;
  logic              accept_data;

  assign byte_done   = scl_fall && full;
  assign accept_data = (byte_idx == 2'd0) || ((byte_idx == 2'd1) && test_on);
  assign ctl_wr      = (state == ST_WBYTE) && byte_done && (byte_idx == 2'd0);
  assign mon_wr      = (state == ST_WBYTE) && byte_done && (byte_idx == 2'd1) && test_on;
  assign wr_byte     = sh_in;
  assign ack_slot    = (state == ST_AACK) || (state == ST_WACK);
  assign rd_slot     = (state == ST_RBYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      full     <= 1'b0;
      sh_in    <= '0;
      sh_out   <= '0;
      rd_cap   <= '0;
      rd_mode  <= 1'b0;
      byte_idx <= 2'd0;
      sda_pull <= 1'b0;
    end else if (bus_start) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      full     <= 1'b0;
      byte_idx <= 2'd0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      state    <= ST_IDLE;
      full     <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise) begin
            sh_in <= {sh_in[BYTE_W-2:0], sda_bit};
            if (bit_cnt == LAST_BIT) full <= 1'b1;
            else bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_done) begin
            full    <= 1'b0;
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (sh_in[BYTE_W-1:1] == my_addr) begin
                sda_pull <= 1'b1;
                state    <= ST_AACK;
                rd_mode  <= sh_in[0];
                rd_cap   <= stat_byte;
                sh_out   <= stat_byte;
              end else begin
                state <= ST_SKIP;
              end
            end else if (accept_data) begin
              sda_pull <= 1'b1;
              state    <= ST_WACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              state    <= ST_RBYTE;
              sda_pull <= ~sh_out[BYTE_W-1];
              bit_cnt  <= '0;
            end else begin
              state    <= ST_WBYTE;
              sda_pull <= 1'b0;
              byte_idx <= 2'd0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= ST_WBYTE;
            if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
          end
        end
        ST_RBYTE: begin
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_pull <= 1'b0;
              state    <= ST_RACK;
              full     <= 1'b0;
            end else begin
              bit_cnt  <= bit_cnt + 1'b1;
              sda_pull <= ~sh_out[BYTE_W-2];
              sh_out   <= {sh_out[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_bit) state <= ST_SKIP;
            else full <= 1'b1;
          end
          if (scl_fall && full) begin
            full     <= 1'b0;
            state    <= ST_RBYTE;
            bit_cnt  <= '0;
            sda_pull <= ~rd_cap[BYTE_W-1];
            sh_out   <= rd_cap;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tvsnd_ctl_regs.sv
module tvsnd_ctl_regs
  import tvsnd_ctl_pkg::*;
#(
  parameter logic [7:0] CTL_INIT = 8'h01,
  parameter int         MON_W    = 4,
  parameter int         MON_LAST = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             mon_wr,
  input  logic [7:0]       wr_byte,
  output ctl_t             ctl_q,
  output logic [MON_W-1:0] mon_q,
  output logic             init_q
);
  localparam logic [7:0] MON_LIMIT = 8'(MON_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= ctl_t'(CTL_INIT);
      mon_q  <= '0;
      init_q <= 1'b1;
    end else if (ctl_wr) begin
      ctl_q  <= merge_ctl(ctl_q, wr_byte);
      init_q <= 1'b0;
      if (!wr_byte[7]) mon_q <= '0;
    end else if (mon_wr && (wr_byte <= MON_LIMIT)) begin
      mon_q <= wr_byte[MON_W-1:0];
    end
  end
endmodule

// File: rtl/tvsnd_ctl_slave.sv
module tvsnd_ctl_slave
  import tvsnd_ctl_pkg::*;
#(
  parameter logic [6:0] ADDR_LOW    = 7'h50,
  parameter logic [6:0] ADDR_OPEN   = 7'h40,
  parameter logic [6:0] ADDR_HIGH   = 7'h42,
  parameter logic [7:0] CTL_INIT    = 8'h01,
  parameter int         SYNC_STAGES = 2,
  parameter int         VOTE_LEN    = 3,
  parameter int         MON_W       = 4,
  parameter int         MON_LAST    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [1:0]       addr_sel,
  input  logic             stereo_det,
  input  logic             bilingual_det,
  output logic             sda_pull,
  output logic             ctl_test,
  output logic             ctl_baseband,
  output logic             ctl_clkout_en,
  output logic             ctl_ext_src,
  output logic             ctl_mute,
  output logic             ctl_force_mono,
  output logic [1:0]       ctl_lang,
  output logic [MON_W-1:0] mon_sel
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, flt_lines;
  logic scl_f, sda_f;
  logic evt_rise, evt_fall, evt_start, evt_stop;
  logic ctl_wr, mon_wr, ack_slot, rd_slot, init_flag;
  logic [7:0] wr_byte, stat_byte, ctl_bits;
  logic [6:0] my_addr;
  ctl_t ctl_q;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    tvsnd_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_LEN   (VOTE_LEN),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk (clk),
      .rst_n(rst_n),
      .din (raw_lines[g]),
      .dout(flt_lines[g])
    );
  end

  assign scl_f = flt_lines[0];
  assign sda_f = flt_lines[1];

  tvsnd_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (evt_rise),
    .scl_fall (evt_fall),
    .bus_start(evt_start),
    .bus_stop (evt_stop)
  );

  assign my_addr   = pick_addr(addr_sel, ADDR_LOW, ADDR_OPEN, ADDR_HIGH);
  assign stat_byte = status_byte(stereo_det, bilingual_det, init_flag);

  tvsnd_byte_engine #(.BYTE_W(8)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (evt_rise),
    .scl_fall (evt_fall),
    .bus_start(evt_start),
    .bus_stop (evt_stop),
    .sda_bit  (sda_f),
    .my_addr  (my_addr),
    .test_on  (ctl_q.test),
    .stat_byte(stat_byte),
    .sda_pull (sda_pull),
    .ctl_wr   (ctl_wr),
    .mon_wr   (mon_wr),
    .wr_byte  (wr_byte),
    .ack_slot (ack_slot),
    .rd_slot  (rd_slot)
  );

  tvsnd_ctl_regs #(
    .CTL_INIT(CTL_INIT),
    .MON_W   (MON_W),
    .MON_LAST(MON_LAST)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (ctl_wr),
    .mon_wr (mon_wr),
    .wr_byte(wr_byte),
    .ctl_q  (ctl_q),
    .mon_q  (mon_sel),
    .init_q (init_flag)
  );

  assign ctl_bits       = ctl_q;
  assign ctl_test       = ctl_q.test;
  assign ctl_baseband   = ctl_q.baseband;
  assign ctl_clkout_en  = ctl_q.clkout;
  assign ctl_ext_src    = ctl_q.ext_src;
  assign ctl_mute       = ctl_q.mute;
  assign ctl_force_mono = ctl_q.mono;
  assign ctl_lang       = ctl_q.lang;
endmodule

// File: rtl/tvsnd_ctl_slave_chk.sv
module tvsnd_ctl_slave_chk #(
  parameter int MON_W    = 4,
  parameter int MON_LAST = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_pull,
  input logic             evt_fall,
  input logic             evt_start,
  input logic             evt_stop,
  input logic             ack_slot,
  input logic             rd_slot,
  input logic             ctl_wr,
  input logic             mon_wr,
  input logic [7:0]       ctl_bits,
  input logic [MON_W-1:0] mon_sel,
  input logic             init_flag
);
  assert_pull_in_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (ack_slot || rd_slot));

  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !sda_pull);

  assert_pull_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_fall && !evt_start && !evt_stop) |=> $stable(sda_pull));

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_bits));

  assert_lang_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_bits[1:0] != 2'b11);

  assert_init_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !init_flag |=> !init_flag);

  assert_init_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !init_flag);

  assert_mon_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mon_sel) <= MON_LAST);

  assert_mon_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_wr && !ctl_wr) |=> $stable(mon_sel));
endmodule

bind tvsnd_ctl_slave tvsnd_ctl_slave_chk #(
  .MON_W   (MON_W),
  .MON_LAST(MON_LAST)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_pull (sda_pull),
  .evt_fall (evt_fall),
  .evt_start(evt_start),
  .evt_stop (evt_stop),
  .ack_slot (ack_slot),
  .rd_slot  (rd_slot),
  .ctl_wr   (ctl_wr),
  .mon_wr   (mon_wr),
  .ctl_bits (ctl_bits),
  .mon_sel  (mon_sel),
  .init_flag(init_flag)
);

// File: tb/tvsnd_ctl_slave_tb_top.sv
module tvsnd_ctl_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic stereo_det = 1'b0, bilingual_det = 1'b0;
  logic sda_pull, ctl_test, ctl_baseband, ctl_clkout_en, ctl_ext_src;
  logic ctl_mute, ctl_force_mono;
  logic [1:0] ctl_lang;
  logic [3:0] mon_sel;
  logic sda_line;

  int checks = 0, failures = 0;
  bit cmp_en = 1'b0, glitch_on = 1'b0, done = 1'b0;

  // reference model state
  logic [7:0] exp_ctl = 8'h01;
  int exp_mon = 0;
  bit exp_init = 1'b1;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  tvsnd_ctl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_sel(addr_sel), .stereo_det(stereo_det), .bilingual_det(bilingual_det),
    .sda_pull(sda_pull), .ctl_test(ctl_test), .ctl_baseband(ctl_baseband),
    .ctl_clkout_en(ctl_clkout_en), .ctl_ext_src(ctl_ext_src), .ctl_mute(ctl_mute),
    .ctl_force_mono(ctl_force_mono), .ctl_lang(ctl_lang), .mon_sel(mon_sel)
  );

  function automatic logic [7:0] out_ctl();
    return {ctl_test, ctl_baseband, ctl_clkout_en, ctl_ext_src,
            ctl_mute, ctl_force_mono, ctl_lang};
  endfunction

  function automatic logic [6:0] model_addr(input logic [1:0] sel);
    if (sel == 2'b00) return 7'h50;
    if (sel == 2'b10) return 7'h42;
    return 7'h40;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bus is idle
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(out_ctl() == exp_ctl, "R6 control outputs", 32'(out_ctl()), 32'(exp_ctl));
      chk(32'(mon_sel) == exp_mon, "R9 monitor select", 32'(mon_sel), exp_mon);
      chk(sda_pull == 1'b0, "R12 idle release", 32'(sda_pull), 0);
    end
  end

  task automatic hclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hclk(20);
    scl_m = 1'b1; hclk(40);
    sda_m = 1'b0; hclk(40);
    scl_m = 1'b0; hclk(20);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hclk(20);
    scl_m = 1'b1; hclk(40);
    sda_m = 1'b1; hclk(40);
  endtask

  task automatic put_bit(input logic b);
    hclk(10);
    sda_m = b;
    if (glitch_on) begin
      hclk(10); scl_m = 1'b1; hclk(2); scl_m = 1'b0; hclk(18);
    end else hclk(30);
    scl_m = 1'b1;
    if (glitch_on) begin
      hclk(15); sda_m = ~b; hclk(2); sda_m = b; hclk(23);
    end else hclk(40);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hclk(40);
    scl_m = 1'b1; hclk(20);
    b = sda_line; hclk(20);
    scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input string req);
    bit ack, live, eack;
    logic [7:0] d, nc;
    cmp_en = 1'b0;
    bus_start();
    put_byte({a, 1'b0}, ack);
    live = (a == model_addr(addr_sel));
    chk(ack == live, {req, " R1 address ack"}, 32'(ack), 32'(live));
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
      put_byte(d, ack);
      eack = 1'b0;
      if (live) begin
        if (k == 0) begin
          eack = 1'b1;
          nc = d;
          if (d[1:0] == 2'b11) nc[1:0] = exp_ctl[1:0];
          exp_ctl = nc;
          exp_init = 1'b0;
          if (!d[7]) exp_mon = 0;
        end else if (k == 1 && exp_ctl[7]) begin
          eack = 1'b1;
          if (d <= 8'h0A) exp_mon = int'(d);
        end
      end
      if (!eack) live = 1'b0;
      chk(ack == eack, {req, " R10 data ack"}, 32'(ack), 32'(eack));
    end
    bus_stop();
    hclk(10);
    cmp_en = 1'b1;
  endtask

  task automatic do_partial(input logic [6:0] a, input logic [7:0] d, input int nbits);
    bit ack;
    cmp_en = 1'b0;
    bus_start();
    put_byte({a, 1'b0}, ack);
    chk(ack, "R4 address ack before cut", 32'(ack), 1);
    for (int i = 0; i < nbits; i++) put_bit(d[7 - i]);
    bus_stop();
    hclk(10);
    cmp_en = 1'b1;
  endtask

  task automatic do_read(input logic [6:0] a, input bit flip, input string req);
    bit ack, ematch;
    logic [7:0] v, ev;
    cmp_en = 1'b0;
    ev = {stereo_det, bilingual_det, exp_init, 5'b00000};
    ematch = (a == model_addr(addr_sel));
    bus_start();
    put_byte({a, 1'b1}, ack);
    chk(ack == ematch, {req, " R1 read address ack"}, 32'(ack), 32'(ematch));
    if (flip) begin
      stereo_det = ~stereo_det;
      bilingual_det = ~bilingual_det;
    end
    get_byte(1'b0, v);
    if (!ematch) ev = 8'hFF;
    chk(v == ev, {req, " R3 read byte"}, 32'(v), 32'(ev));
    bus_stop();
    hclk(10);
    cmp_en = 1'b1;
  endtask

  initial begin
    hclk(10);
    rst_n = 1'b1;
    hclk(10);
    // R5: reset state
    chk(out_ctl() == 8'h01, "R5 reset control", 32'(out_ctl()), 32'h01);
    chk(mon_sel == 4'd0, "R5 reset monitor", 32'(mon_sel), 0);
    chk(sda_pull == 1'b0, "R5 reset sda release", 32'(sda_pull), 0);
    cmp_en = 1'b1;
    hclk(20);

    stereo_det = 1'b1; bilingual_det = 1'b0;
    do_read(7'h40, 1'b0, "R5 init flag read");                   // 0xA0
    do_read(7'h50, 1'b0, "R2 wrong read address");
    do_write(7'h50, 1, 8'h2E, 8'h00, 8'h00, "R2 wrong write address");
    do_write(7'h40, 1, 8'h2E, 8'h00, 8'h00, "R6 control write");
    stereo_det = 1'b0; bilingual_det = 1'b1;
    do_read(7'h40, 1'b1, "R7 init cleared, flags captured");
    do_write(7'h40, 1, 8'h0B, 8'h00, 8'h00, "R8 language 11");
    do_partial(7'h40, 8'h00, 5);                                 // R4
    do_partial(7'h40, 8'hFF, 7);                                 // R4
    do_write(7'h40, 2, 8'h81, 8'h07, 8'h00, "R9 monitor select");
    do_write(7'h40, 2, 8'h81, 8'h0C, 8'h00, "R9 monitor out of range");
    do_write(7'h40, 2, 8'h01, 8'h05, 8'h00, "R10 second byte without test");
    do_write(7'h40, 3, 8'h80, 8'h03, 8'h44, "R10 third byte");
    addr_sel = 2'b10;
    do_write(7'h40, 1, 8'h55, 8'h00, 8'h00, "R1 high select old address");
    do_write(7'h42, 1, 8'h45, 8'h00, 8'h00, "R1 high select");
    addr_sel = 2'b00;
    do_write(7'h50, 1, 8'h12, 8'h00, 8'h00, "R1 low select");
    addr_sel = 2'b11;
    do_read(7'h40, 1'b0, "R1 select 11 as open");
    addr_sel = 2'b01;
    glitch_on = 1'b1;
    do_write(7'h40, 2, 8'hE5, 8'h0A, 8'h00, "R11 glitch filter");
    glitch_on = 1'b0;
    do_read(7'h40, 1'b0, "R11 read after glitches");
    hclk(20);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule